// File: doc/BRIEF.md
# Reference Divider with Loss Monitor

The block turns a clock-enable stream of input pulses, nominally at 8 MHz, into a 1.5625 kHz square-wave reference. It divides by 5120 through three counting stages: divide-by-5, then divide-by-4, then divide-by-256. The last stage is split at its midpoint, so the output has a 50 percent duty cycle. The block also raises a one-cycle strobe on each rising edge of the reference.

An activity monitor counts system clock cycles since the last edge of the reference. If no edge comes within the timeout, it sets a failure flag. The timeout defaults to two reference periods, with the clock enable running at full clock rate. The flag clears on the first reference edge after the divider starts moving again. The lamp output is the failure flag ORed with an operator test input. The test input therefore forces the lamp on and changes nothing else.

Top module: `refdiv_mon`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `ref_out` low, `ref_stb` low and the failure flag clear. With `test` low, `fail_lamp` then reads 0.
- R2: After reset, `ref_out` goes high on the edge that takes the 2560th `tick`. It goes low on the 5120th `tick` and high again on the 7680th. The period is therefore 5120 ticks, with 2560 high and 2560 low.
- R3: The divider advances only on clock edges where `tick` is high. With `tick` low, `ref_out` holds and `ref_stb` stays low, and the division ratio counts ticks, not clocks.
- R4: `ref_stb` is high for exactly one clock, in the cycle where `ref_out` first reads high. It occurs once per reference period.
- R5: With `WD_CYC` = 10240 (the default), the failure flag sets after `WD_CYC` consecutive clock edges with no `ref_out` edge, and not earlier. Either edge restarts the count.
- R6: A set failure flag clears in the same cycle that `ref_out` next changes level.
- R7: `fail_lamp` is high whenever `test` is high. `test` changes neither the divider nor the failure flag, so the lamp drops back to the flag value on release.
- R8: A reset applied while `ref_out` is high returns the block to the R1 state. The next rising edge then comes after another 2560 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Input clock enable, one pulse per 8 MHz period |
| test | input | 1 | Lamp test, forces `fail_lamp` high |
| ref_out | output | 1 | 1.5625 kHz square-wave reference |
| ref_stb | output | 1 | One-cycle pulse on each rising edge of `ref_out` |
| fail_lamp | output | 1 | Failure indicator drive |

## Verification
The hardest condition to reach from the ports is recovery after a loss. To get there, the divider must freeze long enough for the timeout to expire. It must then restart and take a full half period before the flag may drop. The bench holds `tick` low for exactly `WD_CYC` clocks to set the flag. It then resumes ticks and checks that the lamp stays on through tick 2559 and goes off on tick 2560, the edge where `ref_out` rises. A half-rate tick pattern confirms that the division counts ticks rather than clocks.

// File: rtl/refdiv_mon.sv
module refdiv_mon #(
  parameter int DIV_A  = 5,
  parameter int DIV_B  = 4,
  parameter int DIV_C  = 256,
  parameter int WD_CYC = 2 * DIV_A * DIV_B * DIV_C
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic test,
  output logic ref_out,
  output logic ref_stb,
  output logic fail_lamp
);

  localparam int AW   = $clog2(DIV_A);
  localparam int BW   = $clog2(DIV_B);
  localparam int CW   = $clog2(DIV_C);
  localparam int WW   = $clog2(WD_CYC);
  localparam int HALF = DIV_C / 2;

  localparam logic [AW-1:0] A_TOP  = AW'(DIV_A - 1);
  localparam logic [BW-1:0] B_TOP  = BW'(DIV_B - 1);
  localparam logic [CW-1:0] C_TOP  = CW'(DIV_C - 1);
  localparam logic [CW-1:0] C_MID  = CW'(HALF - 1);
  localparam logic [CW-1:0] C_HALF = CW'(HALF);
  localparam logic [WW-1:0] WD_TOP = WW'(WD_CYC - 1);

  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [CW-1:0] c_q;
  logic [WW-1:0] wd_q;
  logic          fail_q;

  logic a_wrap, b_wrap, rise, toggle;

  assign a_wrap = tick && (a_q == A_TOP);
  assign b_wrap = a_wrap && (b_q == B_TOP);
  assign rise   = b_wrap && (c_q == C_MID);
  assign toggle = rise || (b_wrap && (c_q == C_TOP));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (tick) begin
      a_q <= a_wrap ? '0 : a_q + 1'b1;
      if (a_wrap) b_q <= (b_q == B_TOP) ? '0 : b_q + 1'b1;
      if (b_wrap) c_q <= (c_q == C_TOP) ? '0 : c_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_stb <= 1'b0;
    else     ref_stb <= rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q   <= '0;
      fail_q <= 1'b0;
    end else if (toggle) begin
      wd_q   <= '0;
      fail_q <= 1'b0;
    end else if (wd_q == WD_TOP) begin
      fail_q <= 1'b1;
    end else begin
      wd_q <= wd_q + 1'b1;
    end
  end

  assign ref_out   = (c_q >= C_HALF);
  assign fail_lamp = fail_q | test;

endmodule

// File: rtl/refdiv_mon_chk.sv
module refdiv_mon_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic test,
  input logic ref_out,
  input logic ref_stb,
  input logic fail_lamp,
  input logic fail
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ref_out && !ref_stb && !fail));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> ($stable(ref_out) && !ref_stb));

  a_r4_stb_on_rise: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && !$past(rst)) |-> (ref_out && !$past(ref_out)));

  a_r5_set_without_edge: assert property (@(posedge clk) disable iff (rst)
    ($rose(fail) && !$past(rst)) |-> $stable(ref_out));

  a_r6_clear_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fail) && !$stable(ref_out)) |-> !fail);

  a_r7_lamp_covers_flag: assert property (@(posedge clk) disable iff (rst)
    (fail || test) |-> fail_lamp);

endmodule

bind refdiv_mon refdiv_mon_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .test(test),
  .ref_out(ref_out), .ref_stb(ref_stb), .fail_lamp(fail_lamp), .fail(fail_q)
);

// File: tb/refdiv_mon_tb.sv
module refdiv_mon_tb;
  localparam int WD = 10240;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic test = 1'b0;
  logic ref_out, ref_stb, fail_lamp;
  int checks = 0;
  int errors = 0;
  int stb_cnt;

  always #2.5 clk = ~clk;

  refdiv_mon u_dut (
    .clk(clk), .rst(rst), .tick(tick), .test(test),
    .ref_out(ref_out), .ref_stb(ref_stb), .fail_lamp(fail_lamp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t);
    tick = t;
    @(negedge clk);
    if (ref_stb === 1'b1) stb_cnt++;
  endtask

  task automatic run(input int n, input logic t);
    for (int i = 0; i < n; i++) cyc(t);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run(3, 1'b1);
    rst = 1'b0;
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ref_out", ref_out, 1'b0);
    chk("R1 ref_stb", ref_stb, 1'b0);
    chk("R1 fail_lamp", fail_lamp, 1'b0);
  endtask

  task automatic t_divide();
    do_reset();
    stb_cnt = 0;
    run(2559, 1'b1);
    chk("R2 low before 2560", ref_out, 1'b0);
    chk("R4 no early stb", ref_stb, 1'b0);
    cyc(1'b1);
    chk("R2 rise at 2560", ref_out, 1'b1);
    chk("R4 stb with rise", ref_stb, 1'b1);
    cyc(1'b1);
    chk("R4 stb one cycle", ref_stb, 1'b0);
    run(2558, 1'b1);
    chk("R2 high at 5119", ref_out, 1'b1);
    cyc(1'b1);
    chk("R2 fall at 5120", ref_out, 1'b0);
    run(2559, 1'b1);
    chk("R2 low at 7679", ref_out, 1'b0);
    cyc(1'b1);
    chk("R2 rise at 7680", ref_out, 1'b1);
    chk("R4 stb per period", ref_stb, 1'b1);
    checks++;
    if (stb_cnt != 2) begin
      errors++;
      $display("FAIL R4 stb count actual=%0d expected=2", stb_cnt);
    end
    chk("R5 no fail while toggling", fail_lamp, 1'b0);
  endtask

  task automatic t_half_rate();
    do_reset();
    for (int i = 0; i < 2559; i++) begin
      cyc(1'b1);
      cyc(1'b0);
    end
    chk("R3 held low at 2559 ticks", ref_out, 1'b0);
    chk("R3 no stb without tick", ref_stb, 1'b0);
    cyc(1'b1);
    chk("R3 rise counts ticks", ref_out, 1'b1);
    chk("R5 no fail at half rate", fail_lamp, 1'b0);
  endtask

  task automatic t_loss_recover();
    do_reset();
    run(WD - 1, 1'b0);
    chk("R5 not yet failed", fail_lamp, 1'b0);
    cyc(1'b0);
    chk("R5 fail after timeout", fail_lamp, 1'b1);
    run(100, 1'b0);
    chk("R5 fail holds", fail_lamp, 1'b1);
    run(2559, 1'b1);
    chk("R6 fail until edge", fail_lamp, 1'b1);
    cyc(1'b1);
    chk("R6 ref edge", ref_out, 1'b1);
    chk("R6 fail clears on edge", fail_lamp, 1'b0);
  endtask

  task automatic t_lamp_test();
    do_reset();
    run(10, 1'b1);
    test = 1'b1;
    #1;
    chk("R7 test forces lamp", fail_lamp, 1'b1);
    run(2549, 1'b1);
    chk("R7 divider unaffected", ref_out, 1'b0);
    cyc(1'b1);
    chk("R7 rise on schedule", ref_out, 1'b1);
    test = 1'b0;
    #1;
    chk("R7 release restores lamp", fail_lamp, 1'b0);
  endtask

  task automatic t_mid_reset();
    do_reset();
    run(3000, 1'b1);
    chk("R8 high before reset", ref_out, 1'b1);
    rst = 1'b1;
    cyc(1'b1);
    rst = 1'b0;
    chk("R8 ref cleared", ref_out, 1'b0);
    chk("R8 lamp clear", fail_lamp, 1'b0);
    run(2559, 1'b1);
    chk("R8 low at 2559", ref_out, 1'b0);
    cyc(1'b1);
    chk("R8 rise at 2560", ref_out, 1'b1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_divide();
        t_half_rate();
        t_loss_recover();
        t_lamp_test();
        t_mid_reset();
      end
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule